// File: doc/BRIEF.md
# Block Protection Trailer Insert and Check Unit

This unit sits in a byte stream of fixed-size logical blocks (512 data bytes by default). Each block may carry an 8-byte protection trailer made of a 16-bit guard, a 16-bit application tag and a 32-bit reference tag. A command selects one of four operations: insert a fresh trailer after the data, check and remove the trailer, check and forward it unchanged, or check it and forward a rewritten trailer. The command stays in force for any number of blocks until the next command.

Each command sets the guard type, the initial value of each tag, whether each tag takes part, and whether each tag counts up from block to block. The guard is either a CRC-16 or a 16-bit ones-complement checksum. Once per block the unit reports three error flags: guard, application tag and reference tag. Every output byte appears one cycle after the input byte that produced it. During insertion the unit stalls its input for eight cycles while it issues the trailer.

Top module: `dif_unit`

## Requirements
- R1: After reset, and until the first `cmd_start`, `in_ready`, `out_valid` and `sts_valid` are low.
- R2: Insert mode (`cmd_mode`=0) accepts 512 data bytes and forwards them unchanged. It then holds `in_ready` low and emits 8 trailer bytes: guard, then application tag, then reference tag, each most significant byte first.
- R3: With `cmd_guard_sel`=0 the guard is the CRC-16 of the block's data bytes. The polynomial is 0x8BB7, the start value 0, bits are taken most significant first, and there is no final inversion.
- R4: With `cmd_guard_sel`=1 the guard is the bitwise inverse of the end-around-carry sum of the data taken as big-endian 16-bit words, starting from 0. All-zero data gives 0xFFFF and all-0xFF data gives 0x0000.
- R5: Each tag starts at its `cmd_*_init` value when a command begins. After each block it increments by one, wrapping at its width, when its increment enable is set.
- R6: A disabled tag is written as all ones on insertion and never raises its error flag.
- R7: Strip mode (`cmd_mode`=1) accepts 520 bytes per block and outputs only the 512 data bytes.
- R8: Pass mode (`cmd_mode`=2) accepts 520 bytes per block and outputs all of them unchanged.
- R9: Replace mode (`cmd_mode`=3) outputs the data unchanged and the guard recomputed from the data. Each enabled tag carries its current value. Each disabled tag passes its received bytes through.
- R10: `sts_valid` pulses once per block, one cycle after the last trailer byte is accepted or issued. The guard flag is set when the received guard differs from the computed one. Each tag flag is set when that tag is enabled and its received value differs from the current value. In insert mode all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Loads a new command and restarts block framing |
| cmd_mode | input | 2 | 0 insert, 1 strip, 2 pass, 3 replace |
| cmd_guard_sel | input | 1 | 0 CRC-16 guard, 1 checksum guard |
| cmd_app_en | input | 1 | Application tag takes part |
| cmd_ref_en | input | 1 | Reference tag takes part |
| cmd_app_inc | input | 1 | Application tag counts up per block |
| cmd_ref_inc | input | 1 | Reference tag counts up per block |
| cmd_app_init | input | 16 | Initial application tag |
| cmd_ref_init | input | 32 | Initial reference tag |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Unit accepts the input byte |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| sts_valid | output | 1 | Per-block status strobe |
| sts_guard_err | output | 1 | Guard mismatch |
| sts_app_err | output | 1 | Application tag mismatch |
| sts_ref_err | output | 1 | Reference tag mismatch |

## Verification
The bench runs all-zero and all-ones data through the checksum guard. A design that drops the end-around carry, or that inverts the result twice, produces the wrong guard bytes there. A reference tag that starts at 0xFFFFFFFF and auto-increments shows whether the count wraps to zero on the second block. Random blocks corrupt one trailer field at a time, including the field of a disabled tag. A unit that checks a disabled tag, or that blames the wrong field, raises the wrong status flag. Comparing the insert and replace streams byte by byte catches a swapped trailer order or byte order, and catches a trailer that leaks out in strip mode.

// File: rtl/dif_pkg.sv
package dif_pkg;
   typedef enum logic [1:0] {
      MODE_INSERT  = 2'd0,
      MODE_STRIP   = 2'd1,
      MODE_PASS    = 2'd2,
      MODE_REPLACE = 2'd3
   } dif_mode_e;

   typedef struct packed {
      dif_mode_e mode;
      logic      gsel;
      logic      app_en;
      logic      ref_en;
      logic      app_inc;
      logic      ref_inc;
   } dif_cfg_t;

   localparam int TRAILER_BYTES = 8;
endpackage

// File: rtl/dif_crc16.sv
module dif_crc16 #(
   parameter logic [15:0] POLY = 16'h8BB7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [7:0]  byte_i,
   output logic [15:0] guard_o
);
   logic [15:0] crc_q;

   function automatic logic [15:0] crc_byte(input logic [15:0] c_in, input logic [7:0] b);
      logic [15:0] c;
      c = c_in ^ {b, 8'h00};
      for (int i = 0; i < 8; i++) begin
         c = c[15] ? ((c << 1) ^ POLY) : (c << 1);
      end
      return c;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= '0;
      else if (clr)   crc_q <= '0;
      else if (en)    crc_q <= crc_byte(crc_q, byte_i);
   end

   assign guard_o = crc_q;

   // R3: each block starts from a zero remainder
   p_crc_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (guard_o == 16'h0000));
endmodule

// File: rtl/dif_csum16.sv
module dif_csum16 (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [7:0]  byte_i,
   output logic [15:0] guard_o
);
   logic [15:0] sum_q;
   logic [7:0]  hi_q;
   logic        odd_q;
   logic [16:0] raw;
   logic [15:0] folded;

   always_comb begin
      raw    = {1'b0, sum_q} + {1'b0, hi_q, byte_i};
      folded = raw[15:0] + {15'd0, raw[16]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         hi_q  <= '0;
         odd_q <= 1'b0;
      end else if (clr) begin
         sum_q <= '0;
         hi_q  <= '0;
         odd_q <= 1'b0;
      end else if (en) begin
         odd_q <= ~odd_q;
         if (!odd_q) hi_q  <= byte_i;
         else        sum_q <= folded;
      end
   end

   assign guard_o = ~sum_q;

   // R4: an empty sum inverts to all ones
   p_csum_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (guard_o == 16'hFFFF));
endmodule

// File: rtl/dif_tag_ctr.sv
module dif_tag_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] init,
   input  logic         bump,
   output logic [W-1:0] val
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     val <= '0;
      else if (load)  val <= init;
      else if (bump)  val <= val + W'(1);
   end

   // R5: a block end with counting enabled advances by exactly one
   p_tag_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && !load) |=> (val == $past(val) + W'(1)));
   p_tag_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (val == $past(init)));
endmodule

// File: rtl/dif_unit.sv
module dif_unit
   import dif_pkg::*;
#(
   parameter int BLOCK_BYTES = 512,
   parameter bit HAS_CSUM    = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_start,
   input  logic [1:0]  cmd_mode,
   input  logic        cmd_guard_sel,
   input  logic        cmd_app_en,
   input  logic        cmd_ref_en,
   input  logic        cmd_app_inc,
   input  logic        cmd_ref_inc,
   input  logic [15:0] cmd_app_init,
   input  logic [31:0] cmd_ref_init,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   output logic        in_ready,
   output logic        out_valid,
   output logic [7:0]  out_data,
   output logic        sts_valid,
   output logic        sts_guard_err,
   output logic        sts_app_err,
   output logic        sts_ref_err
);
   localparam int FRAME = BLOCK_BYTES + TRAILER_BYTES;
   localparam int CNT_W = $clog2(FRAME);
   localparam logic [CNT_W-1:0] BLK_C  = CNT_W'(BLOCK_BYTES);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME - 1);

   generate
      if (BLOCK_BYTES < 2 || (BLOCK_BYTES % 2) != 0) begin : g_bad_block
         $error("BLOCK_BYTES must be an even count of at least 2");
      end
   endgenerate

   dif_cfg_t         cfg_q;
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic             data_ph, is_ins, step, last, blk_end;
   logic [2:0]       tidx;
   logic [15:0]      crc_v, csum_v, guard_v, app_v, gen_app;
   logic [31:0]      ref_v, gen_ref;
   logic [63:0]      exp_w, gen_w;
   logic [7:0]       exp_b, gen_b, trl_b;
   logic             f_guard, f_app, f_ref, mism, chk;
   logic             g_cur, a_cur, r_cur, g_acc, a_acc, r_acc;
   logic             emit;

   // framing
   assign data_ph  = (cnt_q < BLK_C);
   assign is_ins   = (cfg_q.mode == MODE_INSERT);
   assign in_ready = armed_q && !(is_ins && !data_ph);
   assign step     = (in_valid && in_ready) || (armed_q && is_ins && !data_ph);
   assign last     = (cnt_q == LAST_C);
   assign blk_end  = step && last;
   assign tidx     = cnt_q[2:0] - BLK_C[2:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (cmd_start) begin
         cfg_q   <= '{mode: dif_mode_e'(cmd_mode), gsel: cmd_guard_sel,
                      app_en: cmd_app_en, ref_en: cmd_ref_en,
                      app_inc: cmd_app_inc, ref_inc: cmd_ref_inc};
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (step) begin
         cnt_q   <= last ? '0 : cnt_q + CNT_W'(1);
      end
   end

   // guard engines
   dif_crc16 u_crc (
      .clk(clk), .rst_n(rst_n), .clr(cmd_start || blk_end),
      .en(step && data_ph), .byte_i(in_data), .guard_o(crc_v));

   generate
      if (HAS_CSUM) begin : g_csum
         dif_csum16 u_csum (
            .clk(clk), .rst_n(rst_n), .clr(cmd_start || blk_end),
            .en(step && data_ph), .byte_i(in_data), .guard_o(csum_v));
      end else begin : g_no_csum
         assign csum_v = 16'h0000;
      end
   endgenerate

   assign guard_v = (HAS_CSUM && cfg_q.gsel) ? csum_v : crc_v;

   // tag counters
   dif_tag_ctr #(.W(16)) u_app (
      .clk(clk), .rst_n(rst_n), .load(cmd_start), .init(cmd_app_init),
      .bump(blk_end && cfg_q.app_inc), .val(app_v));
   dif_tag_ctr #(.W(32)) u_ref (
      .clk(clk), .rst_n(rst_n), .load(cmd_start), .init(cmd_ref_init),
      .bump(blk_end && cfg_q.ref_inc), .val(ref_v));

   // trailer bytes: expected for checking, generated for output
   assign gen_app = cfg_q.app_en ? app_v : 16'hFFFF;
   assign gen_ref = cfg_q.ref_en ? ref_v : 32'hFFFF_FFFF;
   assign exp_w   = {guard_v, app_v, ref_v};
   assign gen_w   = {guard_v, gen_app, gen_ref};
   assign exp_b   = exp_w[8*(7 - int'(tidx)) +: 8];
   assign gen_b   = gen_w[8*(7 - int'(tidx)) +: 8];
   assign f_guard = (tidx < 3'd2);
   assign f_app   = (tidx == 3'd2) || (tidx == 3'd3);
   assign f_ref   = tidx[2];

   always_comb begin
      unique case (cfg_q.mode)
         MODE_INSERT:  trl_b = gen_b;
         MODE_PASS:    trl_b = in_data;
         MODE_REPLACE: trl_b = (f_guard || (f_app && cfg_q.app_en) ||
                                (f_ref && cfg_q.ref_en)) ? gen_b : in_data;
         default:      trl_b = in_data;
      endcase
   end

   // checking
   assign chk   = step && !data_ph && !is_ins;
   assign mism  = (in_data != exp_b);
   assign g_cur = chk && f_guard && mism;
   assign a_cur = chk && f_app && mism && cfg_q.app_en;
   assign r_cur = chk && f_ref && mism && cfg_q.ref_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {g_acc, a_acc, r_acc} <= '0;
      end else if (cmd_start || blk_end) begin
         {g_acc, a_acc, r_acc} <= '0;
      end else if (chk) begin
         g_acc <= g_acc | g_cur;
         a_acc <= a_acc | a_cur;
         r_acc <= r_acc | r_cur;
      end
   end

   // output stage
   assign emit = data_ph || (cfg_q.mode != MODE_STRIP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         sts_valid <= 1'b0;
         {sts_guard_err, sts_app_err, sts_ref_err} <= '0;
      end else begin
         out_valid <= step && emit && !cmd_start;
         if (step) out_data <= data_ph ? in_data : trl_b;
         sts_valid <= blk_end && !cmd_start;
         {sts_guard_err, sts_app_err, sts_ref_err} <= (blk_end && !cmd_start) ?
            {g_acc | g_cur, a_acc | a_cur, r_acc | r_cur} : 3'b000;
      end
   end

   // R1: nothing is accepted before a command arrives
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> (!in_ready && !out_valid && !sts_valid));
   // R2: the cycle after the last data byte in insert mode the input is held
   p_ins_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && is_ins && cnt_q == BLK_C - CNT_W'(1) && !cmd_start) |=> !in_ready);
   // R7: strip mode never emits trailer bytes
   p_strip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !data_ph && cfg_q.mode == MODE_STRIP) |=> !out_valid);
   // R10: inserted blocks report clean status
   p_ins_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_end && is_ins) |=> !(sts_guard_err || sts_app_err || sts_ref_err));
   // R10: a status strobe follows a processed byte
   p_sts_after_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sts_valid |-> $past(step));
endmodule

// File: tb/dif_unit_bench.sv
`timescale 1ns/1ps
module dif_unit_bench;
   localparam int BLK = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic [1:0]  cmd_mode = '0;
   logic        cmd_guard_sel = 1'b0, cmd_app_en = 1'b0, cmd_ref_en = 1'b0;
   logic        cmd_app_inc = 1'b0, cmd_ref_inc = 1'b0;
   logic [15:0] cmd_app_init = '0;
   logic [31:0] cmd_ref_init = '0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready, out_valid, sts_valid;
   logic [7:0]  out_data;
   logic        sts_guard_err, sts_app_err, sts_ref_err;

   int total = 0, bad = 0;
   bit finished = 0;
   logic [7:0] outq[$];
   int sts_n = 0;
   logic [2:0] sts_f = '0;
   logic [15:0] m_app;
   logic [31:0] m_ref;

   always #2.5 clk = ~clk;

   dif_unit u_dif_unit (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_mode(cmd_mode),
      .cmd_guard_sel(cmd_guard_sel), .cmd_app_en(cmd_app_en), .cmd_ref_en(cmd_ref_en),
      .cmd_app_inc(cmd_app_inc), .cmd_ref_inc(cmd_ref_inc),
      .cmd_app_init(cmd_app_init), .cmd_ref_init(cmd_ref_init),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .sts_valid(sts_valid),
      .sts_guard_err(sts_guard_err), .sts_app_err(sts_app_err), .sts_ref_err(sts_ref_err));

   always @(negedge clk) begin
      if (out_valid) outq.push_back(out_data);
      if (sts_valid) begin
         sts_n++;
         sts_f = {sts_guard_err, sts_app_err, sts_ref_err};
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(input logic [7:0] d [BLK]);
      logic [15:0] c = 16'h0;
      for (int i = 0; i < BLK; i++) begin
         for (int b = 7; b >= 0; b--) begin
            logic fb;
            fb = c[15] ^ d[i][b];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h8BB7;
         end
      end
      return c;
   endfunction

   function automatic logic [15:0] ref_csum(input logic [7:0] d [BLK]);
      int unsigned s = 0;
      for (int i = 0; i < BLK; i += 2) begin
         s = s + {d[i], d[i+1]};
         if (s > 32'hFFFF) s = (s & 32'hFFFF) + 1;
      end
      return ~s[15:0];
   endfunction

   function automatic string req_of(input int mode);
      case (mode)
         0: return "R2";
         1: return "R7";
         2: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic start_cmd(input int mode, input bit gs, input bit ae, input bit re,
                            input bit ai, input bit ri, input logic [15:0] a0,
                            input logic [31:0] r0);
      @(negedge clk);
      cmd_start = 1; cmd_mode = 2'(mode); cmd_guard_sel = gs;
      cmd_app_en = ae; cmd_ref_en = re; cmd_app_inc = ai; cmd_ref_inc = ri;
      cmd_app_init = a0; cmd_ref_init = r0;
      m_app = a0; m_ref = r0;
      @(negedge clk);
      cmd_start = 0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      bit done = 0;
      while (!done) begin
         @(negedge clk);
         if ($urandom % 8 == 0) in_valid = 0;
         else begin
            in_valid = 1; in_data = b; done = in_ready;
         end
      end
   endtask

   // kind: 0 zeros, 1 ones, 2 random; corrupt: 0 none, 1 guard, 2 app, 3 ref
   task automatic run_block(input int kind, input int corrupt, output logic [15:0] gout);
      logic [7:0] d [BLK];
      logic [7:0] t [8];
      logic [7:0] e [8];
      logic [7:0] expq[$];
      logic [15:0] g, ta;
      logic [31:0] tr;
      logic [2:0] ef;
      int mode = int'(cmd_mode);
      int mm = 0;
      for (int i = 0; i < BLK; i++)
         d[i] = (kind == 0) ? 8'h00 : (kind == 1) ? 8'hFF : 8'($urandom);
      g  = cmd_guard_sel ? ref_csum(d) : ref_crc(d);
      ta = m_app; tr = m_ref;
      if (corrupt == 2) ta = ta ^ 16'h0100;
      if (corrupt == 3) tr = tr ^ 32'h0000_4000;
      t = '{g[15:8] ^ ((corrupt == 1) ? 8'h20 : 8'h00), g[7:0], ta[15:8], ta[7:0],
            tr[31:24], tr[23:16], tr[15:8], tr[7:0]};
      ef = (mode == 0) ? 3'b000 :
           {corrupt == 1, cmd_app_en && corrupt == 2, cmd_ref_en && corrupt == 3};
      for (int i = 0; i < BLK; i++) expq.push_back(d[i]);
      begin
         logic [15:0] ga = cmd_app_en ? m_app : 16'hFFFF;
         logic [31:0] gr = cmd_ref_en ? m_ref : 32'hFFFF_FFFF;
         if (mode == 0)
            e = '{g[15:8], g[7:0], ga[15:8], ga[7:0], gr[31:24], gr[23:16], gr[15:8], gr[7:0]};
         else if (mode == 3)
            e = '{g[15:8], g[7:0],
                  cmd_app_en ? m_app[15:8] : t[2], cmd_app_en ? m_app[7:0] : t[3],
                  cmd_ref_en ? m_ref[31:24] : t[4], cmd_ref_en ? m_ref[23:16] : t[5],
                  cmd_ref_en ? m_ref[15:8] : t[6], cmd_ref_en ? m_ref[7:0] : t[7]};
         else e = t;
      end
      if (mode != 1) for (int i = 0; i < 8; i++) expq.push_back(e[i]);
      outq.delete(); sts_n = 0;
      for (int i = 0; i < BLK; i++) send_byte(d[i]);
      if (mode != 0) for (int i = 0; i < 8; i++) send_byte(t[i]);
      @(negedge clk); in_valid = 0;
      repeat (14) @(negedge clk);
      check(outq.size() == expq.size(), req_of(mode), "output length",
            64'(outq.size()), 64'(expq.size()));
      if (outq.size() == expq.size())
         for (int i = 0; i < expq.size(); i++) if (outq[i] !== expq[i]) mm++;
      // R6 covered here when a tag is disabled in insert mode
      check(mm == 0, (mode == 0 && !(cmd_app_en && cmd_ref_en)) ? "R2/R6" : req_of(mode),
            "byte mismatches", 64'(mm), 64'd0);
      check(sts_n == 1, "R10", "status strobes", 64'(sts_n), 64'd1);
      check(sts_f == ef, (corrupt != 0 && !(ef != 0)) ? "R10/R6" : "R10",
            "status flags", 64'(sts_f), 64'(ef));
      gout = (outq.size() >= BLK + 2) ? {outq[BLK], outq[BLK+1]} : 16'hDEAD;
      if (cmd_app_inc) m_app = m_app + 16'd1;
      if (cmd_ref_inc) m_ref = m_ref + 32'd1;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: run did not complete");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] gq;
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      // R1: idle after reset
      check(!in_ready && !out_valid && !sts_valid, "R1", "idle outputs",
            64'({in_ready, out_valid, sts_valid}), 64'd0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      check(!in_ready && !out_valid && !sts_valid, "R1", "idle before command",
            64'({in_ready, out_valid, sts_valid}), 64'd0);

      // R3: zero data gives a zero CRC
      start_cmd(0, 0, 1, 1, 0, 0, 16'h1234, 32'h0A0B0C0D);
      run_block(0, 0, gq);
      check(gq == 16'h0000, "R3", "crc of zero block", 64'(gq), 64'h0);
      // R4: checksum corners
      start_cmd(0, 1, 1, 1, 0, 0, 16'h0001, 32'h1);
      run_block(0, 0, gq);
      check(gq == 16'hFFFF, "R4", "checksum of zero block", 64'(gq), 64'hFFFF);
      run_block(1, 0, gq);
      check(gq == 16'h0000, "R4", "checksum of ones block", 64'(gq), 64'h0);
      // R5: reference tag wraps
      start_cmd(2, 0, 1, 1, 1, 1, 16'hFFFF, 32'hFFFF_FFFF);
      run_block(2, 0, gq);
      run_block(2, 0, gq);
      check(m_ref == 32'h1, "R5", "model tag after wrap", 64'(m_ref), 64'h1);
      // R6: disabled tags inserted as ones, corruption ignored
      start_cmd(0, 1, 0, 0, 1, 1, 16'h5555, 32'h7777);
      run_block(2, 0, gq);
      start_cmd(1, 0, 0, 1, 0, 1, 16'h2222, 32'h10);
      run_block(2, 2, gq);
      start_cmd(3, 1, 1, 0, 1, 0, 16'h3333, 32'h20);
      run_block(2, 3, gq);

      // random mix across modes
      for (int c = 0; c < 5; c++) begin
         start_cmd($urandom % 4, 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), 16'($urandom), $urandom);
         for (int b = 0; b < 3; b++) run_block(2, $urandom % 4, gq);
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule